// File: doc/BRIEF.md
# PECI Host Controller Register Front-End

This block sits between a processor's register bus and a PECI bus engine. Software programs a target address, a transmit length, a receive length, a command byte and payload bytes. It then sets a start bit. The block latches the transaction parameters and passes the command byte and the payload to the engine, one byte per handshake. It stores the bytes the engine returns in the same data buffer. It then records the outcome in sticky status flags and can raise an interrupt. The wire-level bit timing and the frame check are handled inside the engine, which is not part of this block.

A four-state sequencer runs each transaction:

- **ST_IDLE** moves to ST_SEND when a start write is accepted.
- **ST_SEND** presents bytes until the transmit count is reached. It then moves to ST_RECV. An error pulse from the engine sends it to ST_FINISH instead.
- **ST_RECV** accepts bytes until the receive count is reached. It then moves to ST_FINISH. An error pulse also sends it to ST_FINISH.
- **ST_FINISH** posts the flags and always returns to ST_IDLE on the next cycle.

The register bus is a single-cycle write port with combinational read data. The pull-down and bit-rate fields are driven straight out to the engine.

Top module: `peci_hp_front`

## Requirements
- R1: After reset, the control/status register reads 0x00, the bit-rate register reads 0x0F, `pull_sel` is 0, `bit_rate` is 15 and `irq` is low.
- R2: Writing control/status (offset 0x00) with bit 0 set while idle starts a transaction, and bit 0 reads 1 until the transaction ends. The engine receives the command byte first, then data buffer slots 0, 1, … in order, for a total equal to the write length.
- R3: Received bytes are stored in data buffer slots 0, 1, … in order, up to the read length.
- R4: Every transaction ends with the done flag (control bit 1) set, including failed ones. Busy clears in the same cycle that done is set.
- R5: A `eng_crc_fail` pulse or an `eng_abort` pulse during transmit or receive ends the transaction at once. A CRC failure sets control bit 3 and an abort sets control bit 4, each together with done. Buffer slots beyond the bytes already received are left unchanged.
- R6: The done, CRC and abort flags are cleared by writing 1 to their bit, and writing 0 leaves them unchanged. If hardware sets a flag in the same cycle that software clears it, the set wins.
- R7: `irq` is high exactly when the interrupt enable (control bit 6) is 1 and at least one of done, CRC or abort is set.
- R8: While busy, the following have no effect on the running transaction:
  - a start write;
  - changes to the address, length and command registers, because these values are latched when the transaction starts;
  - bus writes to the data buffer, which are ignored.
- R9: A write or read length above 64 is treated as 64 for the transfer, and the transaction ends with the abort flag set as well as done.
- R10: Register offsets and field widths are as follows. Unused bits read 0 and unmapped offsets read 0.

  | Register | Offset | Field |
  |---|---|---|
  | Read length | 0x04 | bits 6:0 |
  | Target address | 0x08 | 8 bits |
  | Command | 0x0C | 8 bits |
  | Control-2 (pull-down select) | 0x10 | bits 7:6 |
  | Write length | 0x1C | bits 6:0 |
  | Bit rate | 0x2C | bits 4:0 |
  | Data buffer slot n | 0x100 + 4·n | 8 bits |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 9 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |
| pull_sel | output | 2 | Pull-down strength select |
| bit_rate | output | 5 | Negotiated bit-rate divider |
| eng_active | output | 1 | Transaction in progress |
| eng_addr | output | 8 | Latched target address |
| eng_wr_len | output | 7 | Latched, clamped write length |
| eng_rd_len | output | 7 | Latched, clamped read length |
| eng_tx_valid | output | 1 | Transmit byte offered |
| eng_tx_byte | output | 8 | Transmit byte |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Block accepts a received byte |
| eng_crc_fail | input | 1 | One-cycle frame-check failure pulse |
| eng_abort | input | 1 | One-cycle abort pulse |

## Verification
The assertions check the following on every cycle:
- done accompanies the end of busy and the rise of the CRC flag;
- the status flags stay set until a write of 1 clears them;
- transmit and receive never overlap and happen only while busy;
- the latched address holds steady during a transaction;
- the lengths given to the engine never exceed the buffer depth;
- `irq` is quiet when no flag is set.

Only the bench scenarios can show the rest:
- byte order and content on both directions against a queue model;
- early termination at a chosen byte;
- that a restart attempt or a buffer write while busy leaves the transfer untouched;
- the field masks seen through register reads.

// File: rtl/peci_hp_pkg.sv
package peci_hp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_RECV   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    localparam int REG_AW = 9;

    localparam logic [REG_AW-1:0] OFS_CTL   = 9'h000;
    localparam logic [REG_AW-1:0] OFS_RDLEN = 9'h004;
    localparam logic [REG_AW-1:0] OFS_TADDR = 9'h008;
    localparam logic [REG_AW-1:0] OFS_CMD   = 9'h00C;
    localparam logic [REG_AW-1:0] OFS_CTL2  = 9'h010;
    localparam logic [REG_AW-1:0] OFS_WRLEN = 9'h01C;
    localparam logic [REG_AW-1:0] OFS_RATE  = 9'h02C;

    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_CRC  = 3;
    localparam int BIT_ABT  = 4;
    localparam int BIT_IE   = 6;

    localparam int LEN_W     = 7;
    localparam int RATE_W    = 5;
    localparam int PULL_W    = 2;
    localparam logic [RATE_W-1:0] RATE_RESET = 5'd15;

endpackage

// File: rtl/peci_hp_buf.sv
module peci_hp_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_we,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic [7:0]       hw_data,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [7:0]       sw_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [7:0]       rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [7:0]       rd_b_data
);

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hw_we && hw_idx == IDX_W'(g)) begin
                mem[g] <= hw_data;
            end else if (sw_we && sw_idx == IDX_W'(g)) begin
                mem[g] <= sw_data;
            end
        end
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];

endmodule

// File: rtl/peci_hp_seq.sv
module peci_hp_seq
    import peci_hp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] wr_len_in,
    input  logic [LEN_W-1:0] rd_len_in,
    input  logic [7:0]       addr_in,
    input  logic [7:0]       cmd_in,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             crc_fail,
    input  logic             abort_in,
    input  logic [7:0]       buf_rdata,
    output logic             busy,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             rx_ready,
    output logic [IDX_W-1:0] buf_ridx,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    output logic [7:0]       eng_addr,
    output logic [LEN_W-1:0] eng_wr_len,
    output logic [LEN_W-1:0] eng_rd_len,
    output logic             fin,
    output logic             fin_crc,
    output logic             fin_abort
);

    localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] idx_q, wr_q, rd_q;
    logic [7:0]       addr_q, cmd_q;
    logic             over_q, crc_q, abt_q;
    logic             err_pulse;

    function automatic logic [LEN_W-1:0] cap_len(input logic [LEN_W-1:0] l);
        return (l > CAP) ? CAP : l;
    endfunction

    assign err_pulse = crc_fail | abort_in;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_SEND;
            ST_SEND:   if (err_pulse) state_d = ST_FINISH;
                       else if (idx_q == wr_q) state_d = ST_RECV;
            ST_RECV:   if (err_pulse) state_d = ST_FINISH;
                       else if (idx_q == rd_q) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            addr_q <= '0;
            cmd_q  <= '0;
            over_q <= 1'b0;
            crc_q  <= 1'b0;
            abt_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    wr_q   <= cap_len(wr_len_in);
                    rd_q   <= cap_len(rd_len_in);
                    over_q <= (wr_len_in > CAP) || (rd_len_in > CAP);
                    addr_q <= addr_in;
                    cmd_q  <= cmd_in;
                    idx_q  <= '0;
                    crc_q  <= 1'b0;
                    abt_q  <= 1'b0;
                end
                ST_SEND: begin
                    if (err_pulse) begin
                        crc_q <= crc_fail;
                        abt_q <= abort_in;
                    end else if (idx_q == wr_q) begin
                        idx_q <= '0;
                    end else if (tx_ready) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (err_pulse) begin
                        crc_q <= crc_fail;
                        abt_q <= abort_in;
                    end else if (rx_valid && idx_q != rd_q) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        tx_valid  = (state_q == ST_SEND) && (idx_q != wr_q);
        buf_ridx  = IDX_W'(idx_q - 1'b1);
        tx_byte   = (idx_q == '0) ? cmd_q : buf_rdata;
        rx_ready  = (state_q == ST_RECV) && (idx_q != rd_q);
        buf_we    = rx_ready && rx_valid;
        buf_widx  = idx_q[IDX_W-1:0];
        buf_wdata = rx_byte;
        fin       = (state_q == ST_FINISH);
        fin_crc   = crc_q;
        fin_abort = abt_q | over_q;
        eng_addr  = addr_q;
        eng_wr_len = wr_q;
        eng_rd_len = rd_q;
    end

endmodule

// File: rtl/peci_hp_front.sv
module peci_hp_front
    import peci_hp_pkg::*;
#(
    parameter int BUF_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic [PULL_W-1:0] pull_sel,
    output logic [RATE_W-1:0] bit_rate,
    output logic              eng_active,
    output logic [7:0]        eng_addr,
    output logic [LEN_W-1:0]  eng_wr_len,
    output logic [LEN_W-1:0]  eng_rd_len,
    output logic              eng_tx_valid,
    output logic [7:0]        eng_tx_byte,
    input  logic              eng_tx_ready,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_byte,
    output logic              eng_rx_ready,
    input  logic              eng_crc_fail,
    input  logic              eng_abort
);

    localparam int IDX_W = $clog2(BUF_DEPTH);

    logic [LEN_W-1:0]  rdlen_q, wrlen_q;
    logic [7:0]        taddr_q, cmd_q;
    logic [PULL_W-1:0] pd_q;
    logic [RATE_W-1:0] rate_q;
    logic              ie_q, done_q, crc_q, abt_q;

    logic              busy, go, fin, fin_crc, fin_abort;
    logic              ctl_wr, buf_hit, sw_buf_we;
    logic [5:0]        slot;
    logic              hw_we;
    logic [IDX_W-1:0]  hw_idx, rd_b_idx;
    logic [7:0]        hw_data, rd_a_data, rd_b_data;

    assign slot      = reg_addr[7:2];
    assign buf_hit   = reg_addr[8] && (reg_addr[1:0] == 2'b00) &&
                       ({1'b0, slot} < 7'(BUF_DEPTH));
    assign ctl_wr    = reg_wr && (reg_addr == OFS_CTL);
    assign go        = ctl_wr && reg_wdata[BIT_BUSY] && !busy;
    assign sw_buf_we = reg_wr && buf_hit && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdlen_q <= '0;
            wrlen_q <= '0;
            taddr_q <= '0;
            cmd_q   <= '0;
            pd_q    <= '0;
            rate_q  <= RATE_RESET;
            ie_q    <= 1'b0;
            done_q  <= 1'b0;
            crc_q   <= 1'b0;
            abt_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_RDLEN: rdlen_q <= reg_wdata[LEN_W-1:0];
                    OFS_WRLEN: wrlen_q <= reg_wdata[LEN_W-1:0];
                    OFS_TADDR: taddr_q <= reg_wdata;
                    OFS_CMD:   cmd_q   <= reg_wdata;
                    OFS_CTL2:  pd_q    <= reg_wdata[7:6];
                    OFS_RATE:  rate_q  <= reg_wdata[RATE_W-1:0];
                    OFS_CTL:   ie_q    <= reg_wdata[BIT_IE];
                    default: ;
                endcase
            end
            done_q <= fin | (done_q & ~(ctl_wr & reg_wdata[BIT_DONE]));
            crc_q  <= (fin & fin_crc) | (crc_q & ~(ctl_wr & reg_wdata[BIT_CRC]));
            abt_q  <= (fin & fin_abort) | (abt_q & ~(ctl_wr & reg_wdata[BIT_ABT]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (buf_hit) begin
            reg_rdata = rd_a_data;
        end else begin
            case (reg_addr)
                OFS_CTL:   reg_rdata = {1'b0, ie_q, 1'b0, abt_q, crc_q, 1'b0, done_q, busy};
                OFS_RDLEN: reg_rdata = {1'b0, rdlen_q};
                OFS_WRLEN: reg_rdata = {1'b0, wrlen_q};
                OFS_TADDR: reg_rdata = taddr_q;
                OFS_CMD:   reg_rdata = cmd_q;
                OFS_CTL2:  reg_rdata = {pd_q, 6'b0};
                OFS_RATE:  reg_rdata = {3'b0, rate_q};
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign irq        = ie_q & (done_q | crc_q | abt_q);
    assign pull_sel   = pd_q;
    assign bit_rate   = rate_q;
    assign eng_active = busy;

    peci_hp_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_we     (hw_we),
        .hw_idx    (hw_idx),
        .hw_data   (hw_data),
        .sw_we     (sw_buf_we),
        .sw_idx    (slot[IDX_W-1:0]),
        .sw_data   (reg_wdata),
        .rd_a_idx  (slot[IDX_W-1:0]),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data)
    );

    peci_hp_seq #(.DEPTH(BUF_DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .wr_len_in  (wrlen_q),
        .rd_len_in  (rdlen_q),
        .addr_in    (taddr_q),
        .cmd_in     (cmd_q),
        .tx_ready   (eng_tx_ready),
        .rx_valid   (eng_rx_valid),
        .rx_byte    (eng_rx_byte),
        .crc_fail   (eng_crc_fail),
        .abort_in   (eng_abort),
        .buf_rdata  (rd_b_data),
        .busy       (busy),
        .tx_valid   (eng_tx_valid),
        .tx_byte    (eng_tx_byte),
        .rx_ready   (eng_rx_ready),
        .buf_ridx   (rd_b_idx),
        .buf_we     (hw_we),
        .buf_widx   (hw_idx),
        .buf_wdata  (hw_data),
        .eng_addr   (eng_addr),
        .eng_wr_len (eng_wr_len),
        .eng_rd_len (eng_rd_len),
        .fin        (fin),
        .fin_crc    (fin_crc),
        .fin_abort  (fin_abort)
    );

endmodule

// File: rtl/peci_hp_front_chk.sv
module peci_hp_front_chk
    import peci_hp_pkg::*;
#(
    parameter int BUF_DEPTH = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              busy,
    input logic              done_q,
    input logic              crc_q,
    input logic              abt_q,
    input logic              irq,
    input logic              eng_tx_valid,
    input logic              eng_rx_ready,
    input logic [7:0]        eng_addr,
    input logic [LEN_W-1:0]  eng_wr_len,
    input logic [LEN_W-1:0]  eng_rd_len
);

    // R4: the end of busy coincides with done being set
    a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

    // R5: a CRC flag only appears together with done
    a_r5_crc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_q) |-> done_q);

    // R6: done stays set unless a 1 is written to its bit
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(reg_wr && reg_addr == OFS_CTL && reg_wdata[BIT_DONE])) |=> done_q);

    // R2: byte traffic only while busy, never both directions at once
    a_r2_traffic_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_valid || eng_rx_ready) |-> busy);
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_tx_valid && eng_rx_ready));

    // R8: the latched address holds during a transaction
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(eng_addr));

    // R9: lengths handed to the engine are capped at the buffer depth
    a_r9_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr_len <= LEN_W'(BUF_DEPTH)) && (eng_rd_len <= LEN_W'(BUF_DEPTH)));

    // R7: no interrupt without a flag
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q || crc_q || abt_q) |-> !irq);

endmodule

bind peci_hp_front peci_hp_front_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .busy         (busy),
    .done_q       (done_q),
    .crc_q        (crc_q),
    .abt_q        (abt_q),
    .irq          (irq),
    .eng_tx_valid (eng_tx_valid),
    .eng_rx_ready (eng_rx_ready),
    .eng_addr     (eng_addr),
    .eng_wr_len   (eng_wr_len),
    .eng_rd_len   (eng_rd_len)
);

// File: tb/peci_hp_front_bench.sv
module peci_hp_front_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic [1:0] pull_sel;
    logic [4:0] bit_rate;
    logic       eng_active;
    logic [7:0] eng_addr;
    logic [6:0] eng_wr_len, eng_rd_len;
    logic       eng_tx_valid;
    logic [7:0] eng_tx_byte;
    logic       eng_tx_ready = 1'b0;
    logic       eng_rx_valid = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic       eng_rx_ready;
    logic       eng_crc_fail = 1'b0;
    logic       eng_abort = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int crc_at = -1;
    int abort_at = -1;
    int tx_seen = 0;
    int rx_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    peci_hp_front u_peci_hp_front (.*);

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural engine model, compared against the queues every clock
    always @(negedge clk) begin
        eng_tx_ready = 1'b0;
        eng_rx_valid = 1'b0;
        eng_crc_fail = 1'b0;
        eng_abort    = 1'b0;
        if (rst_n) begin
            if (eng_tx_valid && crc_at >= 0 && tx_seen == crc_at) begin
                eng_crc_fail = 1'b1;
                crc_at = -1;
            end else if (eng_tx_valid) begin
                if (txq.size() == 0) chk("R2", 1, 0, "unexpected tx byte");
                else chk("R2", eng_tx_byte, txq.pop_front(), "tx byte");
                eng_tx_ready = 1'b1;
                tx_seen++;
            end
            if (eng_rx_ready && abort_at >= 0 && rx_seen == abort_at) begin
                eng_abort = 1'b1;
                abort_at = -1;
            end else if (eng_rx_ready) begin
                if (rxq.size() == 0) chk("R3", 1, 0, "unexpected rx request");
                else begin
                    eng_rx_byte = rxq.pop_front();
                    eng_rx_valid = 1'b1;
                end
                rx_seen++;
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n = 0;
        do begin
            @(negedge clk);
            #2;
            rd(9'h000, v);
            n++;
        end while (v[0] && n < 500);
        chk("R4", int'(v[0]), 0, "busy clears");
    endtask

    task automatic run(input logic [7:0] a, input logic [7:0] wl, input logic [7:0] rl, input bit ie);
        wr(9'h008, a);
        wr(9'h004, rl);
        wr(9'h01C, wl);
        tx_seen = 0;
        rx_seen = 0;
        wr(9'h000, {1'b0, ie, 5'b0, 1'b1});
        wait_idle();
    endtask

    function automatic logic [8:0] slot_addr(input int n);
        return 9'(9'h100 + 4 * n);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL R4 watchdog expired: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(9'h000, v); chk("R1", v, 8'h00, "ctl after reset");
        rd(9'h02C, v); chk("R1", v, 8'h0F, "rate after reset");
        chk("R1", bit_rate, 15, "bit_rate pin");
        chk("R1", pull_sel, 0, "pull_sel pin");
        chk("R1", irq, 0, "irq after reset");

        // R2 R3 basic write then read
        wr(9'h00C, 8'hA1); wr(slot_addr(0), 8'h11); wr(slot_addr(1), 8'h22);
        txq = '{8'hA1, 8'h11, 8'h22}; rxq = '{8'h5A, 8'hC3};
        run(8'h30, 3, 2, 1'b1);
        rd(9'h000, v); chk("R4", v, 8'h42, "ctl after good transfer");
        chk("R2", txq.size(), 0, "all tx bytes sent");
        chk("R3", rxq.size(), 0, "all rx bytes taken");
        rd(slot_addr(0), v); chk("R3", v, 8'h5A, "rx slot 0");
        rd(slot_addr(1), v); chk("R3", v, 8'hC3, "rx slot 1");
        chk("R8", eng_addr, 8'h30, "latched address");
        chk("R7", irq, 1, "irq with done and enable");

        // R6 write-1-to-clear
        wr(9'h000, 8'h40);
        rd(9'h000, v); chk("R6", v, 8'h42, "writing 0 keeps done");
        wr(9'h000, 8'h42);
        rd(9'h000, v); chk("R6", v, 8'h40, "writing 1 clears done");
        chk("R7", irq, 0, "irq after clear");

        // R5 CRC failure during transmit
        wr(9'h00C, 8'hB2);
        txq = '{8'hB2, 8'h5A}; crc_at = 2;
        run(8'h30, 4, 0, 1'b1);
        rd(9'h000, v); chk("R5", v, 8'h4A, "ctl after crc fail");
        chk("R5", txq.size(), 0, "tx bytes before crc");
        chk("R7", irq, 1, "irq on crc");
        wr(9'h000, 8'h5A);
        rd(9'h000, v); chk("R6", v, 8'h40, "clear crc and done");

        // R5 abort during receive
        wr(9'h00C, 8'hC4);
        txq = '{8'hC4}; rxq = '{8'h77}; abort_at = 1;
        run(8'h30, 1, 3, 1'b1);
        rd(9'h000, v); chk("R5", v, 8'h52, "ctl after abort");
        rd(slot_addr(0), v); chk("R5", v, 8'h77, "slot 0 before abort");
        rd(slot_addr(1), v); chk("R5", v, 8'hC3, "slot 1 untouched by abort");
        wr(9'h000, 8'h1A);

        // R7 enable off, zero lengths
        run(8'h30, 0, 0, 1'b0);
        rd(9'h000, v); chk("R4", v, 8'h02, "done on empty transfer");
        chk("R7", irq, 0, "irq masked");
        wr(9'h000, 8'h02);

        // R8 restart, register and buffer writes while busy
        wr(slot_addr(10), 8'h10);
        wr(9'h00C, 8'hD5);
        for (int i = 0; i < 4; i++) wr(slot_addr(i), 8'(i + 1));
        txq = '{8'hD5, 8'h01, 8'h02, 8'h03, 8'h04};
        rxq = '{8'h09, 8'h08, 8'h07, 8'h06, 8'h05};
        wr(9'h008, 8'h31); wr(9'h004, 8'd5); wr(9'h01C, 8'd5);
        tx_seen = 0; rx_seen = 0;
        wr(9'h000, 8'h41);
        wr(9'h000, 8'h41);
        wr(9'h008, 8'h77);
        wr(slot_addr(10), 8'hEE);
        wr(9'h01C, 8'd2);
        wait_idle();
        chk("R8", eng_addr, 8'h31, "address held from start");
        chk("R8", txq.size(), 0, "tx count from latched length");
        chk("R8", rxq.size(), 0, "rx count from latched length");
        rd(slot_addr(10), v); chk("R8", v, 8'h10, "buffer write ignored while busy");
        rd(9'h008, v); chk("R10", v, 8'h77, "address register updated");
        rd(slot_addr(4), v); chk("R3", v, 8'h05, "rx slot 4");
        rd(9'h000, v); chk("R8", v, 8'h42, "single transaction done");
        wr(9'h000, 8'h42);

        // R9 overlength write
        for (int i = 0; i < 63; i++) wr(slot_addr(i), 8'((i * 3 + 1) & 8'hFF));
        wr(9'h00C, 8'hE6);
        txq = '{8'hE6};
        for (int i = 0; i < 63; i++) txq.push_back(8'((i * 3 + 1) & 8'hFF));
        run(8'h20, 100, 0, 1'b1);
        rd(9'h000, v); chk("R9", v, 8'h52, "abort on overlength");
        chk("R9", txq.size(), 0, "64 bytes sent");
        chk("R9", eng_wr_len, 64, "clamped length");
        rd(9'h01C, v); chk("R10", v, 8'd100, "length register keeps value");
        wr(9'h000, 8'h1A);

        // R10 field masks
        wr(9'h010, 8'hFF); rd(9'h010, v); chk("R10", v, 8'hC0, "ctl2 mask");
        chk("R10", pull_sel, 3, "pull_sel pin");
        wr(9'h02C, 8'hFF); rd(9'h02C, v); chk("R10", v, 8'h1F, "rate mask");
        chk("R10", bit_rate, 31, "bit_rate pin");
        wr(9'h004, 8'hFF); rd(9'h004, v); chk("R10", v, 8'h7F, "length mask");
        rd(9'h014, v); chk("R10", v, 8'h00, "unmapped offset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule